// File: doc/BRIEF.md
# Keyed Flash Command Register Front End

This block is the software-visible register layer in front of an embedded flash engine. A host reaches it through a simple 32-bit port with an 8-bit byte address, a write strobe, a read strobe and combinational read data. It holds five registers: a mode word, a write-only command word, a read-only status word, a read-only result word and a write-protection word.

A command write carries an opcode, a 16-bit argument and an 8-bit key. Only a correctly keyed write of a legal opcode while the engine is idle is forwarded to the engine. It is forwarded as a one-cycle start pulse together with the opcode and the argument. Keyed writes that cannot be accepted raise a sticky command error.

The status word collects sticky error flags from the engine. Each flag has its own clear rule: a status read, a keyed command write, or the start of an accepted command. A protection register can freeze the mode word. An interrupt line reports readiness when the mode word enables it.

Top module: `flash_cmd_regs`

## Requirements
- R1: A write to offset 0x04 whose bits 31:24 equal 0x5A, whose opcode (bits 7:0) is legal and which arrives while not busy raises `cmd_start` for exactly one cycle, starting on the clock edge after the write. During that cycle `cmd_opcode` carries bits 7:0 of the write and `cmd_arg` carries bits 23:8.
- R2: A write to offset 0x04 with any other key value produces no start pulse and leaves every status flag unchanged.
- R3: Legal opcodes are 0x00 to 0x05 and 0x07 to 0x15. A keyed write with opcode 0x06 or any value above 0x15 produces no start and sets the command error flag (status bit 1).
- R4: The block is busy while `eng_busy` is high and during the cycle in which `cmd_start` is high. A keyed write that arrives while busy produces no start and sets status bit 1.
- R5: Status bit 0 (ready) is the inverse of busy. After reset the status word reads 0x00000001.
- R6: Status bit 1 is cleared by a status read (offset 0x08) and by a keyed command write that is accepted.
- R7: Status bit 2 (lock error, set by `lock_err_in`) and bits 16 to 19 (set by `ecc_err_in[0]` to `ecc_err_in[3]`) are sticky until a status read. A set arriving in the same cycle as the read wins; that read still returns the value from before the set.
- R8: Status bit 3 (set by `flash_err_in`) survives status reads and is cleared only when a command is accepted.
- R9: Offset 0x00 stores only the bits in mask 0x04010F01 and reads back the written value ANDed with that mask. It resets to zero.
- R10: A write to offset 0xE4 takes effect only when bits 31:8 equal 0x454643; bit 0 is then the protection enable. Reads of 0xE4 return only bit 0, with the key field reading as zero.
- R11: While protection is enabled, writes to offset 0x00 leave the mode word unchanged.
- R12: Offset 0x0C returns the last `eng_res` value captured while `eng_res_vld` was high. Offset 0x04 and unmapped offsets read as zero.
- R13: `irq` is high exactly when mode bit 0 is set and the block is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a status read clears read-cleared flags |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cmd_start | output | 1 | One-cycle pulse for an accepted command |
| cmd_opcode | output | 8 | Opcode of the accepted command |
| cmd_arg | output | 16 | Argument of the accepted command |
| eng_busy | input | 1 | Engine busy |
| eng_res_vld | input | 1 | Engine result strobe |
| eng_res | input | 32 | Engine result value |
| lock_err_in | input | 1 | Lock error event |
| flash_err_in | input | 1 | Flash operation error event |
| ecc_err_in | input | 4 | ECC error events, one per status bit 16 to 19 |
| irq | output | 1 | Ready interrupt |

## Verification
Two pairs of functions can meet in one cycle. The first is a status read that clears flags while an ECC or lock error event tries to set them. The bench places the read strobe and the event pulse on the same clock. It then expects the read to return the old clear value and the following read to show the flag. The second is a command accepted in one cycle followed by a keyed write in the very next cycle. That second write must be rejected, because the start cycle counts as busy. The scoreboard must see exactly one start, and the command error must appear in the status word.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned OPC_W    = 8;
    localparam int unsigned ARG_W    = 16;
    localparam int unsigned ECC_N    = 4;

    localparam logic [ADDR_W-1:0] OFF_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_RES  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_PROT = 8'hE4;

    localparam logic [7:0]        CMD_KEY   = 8'h5A;
    localparam logic [23:0]       PROT_KEY  = 24'h454643;
    localparam logic [DATA_W-1:0] MODE_MASK = 32'h0401_0F01;

    typedef struct packed {
        logic [ECC_N-1:0] ecc;
        logic             flerr;
        logic             locke;
        logic             cmde;
    } stat_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic              prot_en;
        logic [DATA_W-1:0] result;
        logic              start;
        logic [OPC_W-1:0]  opc;
        logic [ARG_W-1:0]  arg;
    } front_regs_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_LAST = 8'h15,
    parameter logic [OPC_W-1:0] OPC_GAP  = 8'h06
) (
    input  logic [OPC_W-1:0] opc_i,
    output logic             legal_o
);
    always_comb begin
        legal_o = (opc_i <= OPC_LAST) && (opc_i != OPC_GAP);
    end
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_clr_i,
    input  logic             keyed_i,
    input  logic             accept_i,
    input  logic             reject_i,
    input  logic             lock_err_i,
    input  logic             flash_err_i,
    input  logic [ECC_N-1:0] ecc_err_i,
    output stat_flags_t      flags_o
);
    stat_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (rd_clr_i) begin
            flags_d.cmde  = 1'b0;
            flags_d.locke = 1'b0;
            flags_d.ecc   = '0;
        end
        if (keyed_i)     flags_d.cmde  = 1'b0;
        if (reject_i)    flags_d.cmde  = 1'b1;
        if (accept_i)    flags_d.flerr = 1'b0;
        if (lock_err_i)  flags_d.locke = 1'b1;
        if (flash_err_i) flags_d.flerr = 1'b1;
        flags_d.ecc = flags_d.ecc | ecc_err_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_ECC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_err_i != '0) |=> ((flags_q.ecc & $past(ecc_err_i)) == $past(ecc_err_i))); // R7
    AST_FLERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.flerr && !accept_i) |=> flags_q.flerr); // R8
    AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        reject_i |=> flags_q.cmde); // R3
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
    import flash_cmd_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_LAST = 8'h15,
    parameter logic [OPC_W-1:0] OPC_GAP  = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmd_start,
    output logic [OPC_W-1:0]  cmd_opcode,
    output logic [ARG_W-1:0]  cmd_arg,
    input  logic              eng_busy,
    input  logic              eng_res_vld,
    input  logic [DATA_W-1:0] eng_res,
    input  logic              lock_err_in,
    input  logic              flash_err_in,
    input  logic [ECC_N-1:0]  ecc_err_in,
    output logic              irq
);
    localparam int unsigned KEY_LSB = DATA_W - 8;

    front_regs_t regs_d, regs_q;
    stat_flags_t flags;
    logic        legal, busy, keyed, accept, reject, rd_stat;

    flash_cmd_decode #(.OPC_LAST(OPC_LAST), .OPC_GAP(OPC_GAP)) u_decode (
        .opc_i   (bus_wdata[OPC_W-1:0]),
        .legal_o (legal)
    );

    always_comb begin
        busy    = eng_busy | regs_q.start;
        keyed   = bus_wr && (bus_addr == OFF_CMD) && (bus_wdata[DATA_W-1:KEY_LSB] == CMD_KEY);
        accept  = keyed && legal && !busy;
        reject  = keyed && !accept;
        rd_stat = bus_rd && (bus_addr == OFF_STAT);

        regs_d       = regs_q;
        regs_d.start = accept;
        if (accept) begin
            regs_d.opc = bus_wdata[OPC_W-1:0];
            regs_d.arg = bus_wdata[OPC_W+ARG_W-1:OPC_W];
        end
        if (bus_wr && (bus_addr == OFF_MODE) && !regs_q.prot_en)
            regs_d.mode = bus_wdata & MODE_MASK;
        if (bus_wr && (bus_addr == OFF_PROT) && (bus_wdata[DATA_W-1:8] == PROT_KEY))
            regs_d.prot_en = bus_wdata[0];
        if (eng_res_vld)
            regs_d.result = eng_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    flash_cmd_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_clr_i    (rd_stat),
        .keyed_i     (keyed),
        .accept_i    (accept),
        .reject_i    (reject),
        .lock_err_i  (lock_err_in),
        .flash_err_i (flash_err_in),
        .ecc_err_i   (ecc_err_in),
        .flags_o     (flags)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_MODE: bus_rdata = regs_q.mode;
            OFF_STAT: bus_rdata = {{(DATA_W-16-ECC_N){1'b0}}, flags.ecc, 12'b0,
                                   flags.flerr, flags.locke, flags.cmde, ~busy};
            OFF_RES:  bus_rdata = regs_q.result;
            OFF_PROT: bus_rdata = {{(DATA_W-1){1'b0}}, regs_q.prot_en};
            default:  bus_rdata = '0;
        endcase
    end

    assign cmd_start  = regs_q.start;
    assign cmd_opcode = regs_q.opc;
    assign cmd_arg    = regs_q.arg;
    assign irq        = regs_q.mode[0] & ~busy;

    AST_START_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(bus_wr && (bus_addr == OFF_CMD) && (bus_wdata[DATA_W-1:KEY_LSB] == CMD_KEY))); // R1
    AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> ((cmd_opcode <= OPC_LAST) && (cmd_opcode != OPC_GAP))); // R3
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (!$past(eng_busy) && !$past(cmd_start))); // R4
    AST_PROT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.prot_en && bus_wr && (bus_addr == OFF_MODE)) |=> $stable(regs_q.mode)); // R11
    AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy || cmd_start) |-> !irq); // R13
endmodule

// File: tb/flash_cmd_regs_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        cmd_start;
    logic [7:0]  cmd_opcode;
    logic [15:0] cmd_arg;
    logic        eng_busy = 1'b0, eng_res_vld = 1'b0;
    logic [31:0] eng_res = '0;
    logic        lock_err_in = 1'b0, flash_err_in = 1'b0;
    logic [3:0]  ecc_err_in = '0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    logic [23:0] exp_q[$];
    string cur_req = "R1";

    always #10 clk = ~clk;

    flash_cmd_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_start(cmd_start),
        .cmd_opcode(cmd_opcode), .cmd_arg(cmd_arg), .eng_busy(eng_busy),
        .eng_res_vld(eng_res_vld), .eng_res(eng_res), .lock_err_in(lock_err_in),
        .flash_err_in(flash_err_in), .ecc_err_in(ecc_err_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a start pulse is seen
    always @(negedge clk) begin
        if (rst_n && cmd_start) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL %s actual=start(%h,%h) expected=no start", cur_req, cmd_opcode, cmd_arg);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check(cur_req, {8'h0, cmd_arg, cmd_opcode}, {8'h0, e});
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    // driver: pushes the expected command when it should start
    task automatic issue(input string req, input logic [7:0] key, input logic [7:0] opc,
                         input logic [15:0] arg, input bit expect_start);
        cur_req = req;
        if (expect_start) exp_q.push_back({arg, opc});
        bus_write(8'h04, {key, arg, opc});
        @(negedge clk);
        check(req, exp_q.size(), 0);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        bus_read(8'h08, r); check("R5 reset status", r, 32'h1);
        bus_read(8'h00, r); check("R9 reset mode", r, 32'h0);
        check("R13 reset irq", irq, 0);

        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, r); check("R9 mask", r, 32'h0401_0F01);
        #1 check("R13 irq ready", irq, 1);

        issue("R2 bad key", 8'h5B, 8'h01, 16'h0001, 0);
        bus_read(8'h08, r); check("R2 status untouched", r, 32'h1);

        issue("R1 accept", 8'h5A, 8'h03, 16'h1234, 1);
        issue("R1 low edge", 8'h5A, 8'h00, 16'hFFFF, 1);
        issue("R3 top legal", 8'h5A, 8'h15, 16'hA5A5, 1);
        issue("R3 after gap", 8'h5A, 8'h07, 16'h0007, 1);

        issue("R3 gap opcode", 8'h5A, 8'h06, 16'h0000, 0);
        bus_read(8'h08, r); check("R3 cmde set", r, 32'h3);
        bus_read(8'h08, r); check("R6 cleared by read", r, 32'h1);

        issue("R3 above range", 8'h5A, 8'h16, 16'h0000, 0);
        issue("R2 bad key keeps cmde", 8'h00, 8'h01, 16'h0000, 0);
        bus_read(8'h08, r); check("R2 cmde kept", r, 32'h3);
        issue("R3 above range", 8'h5A, 8'hFF, 16'h0000, 0);
        issue("R6 accept clears", 8'h5A, 8'h02, 16'h0BEE, 1);
        bus_read(8'h08, r); check("R6 cleared by command", r, 32'h1);

        eng_busy = 1'b1;
        bus_read(8'h08, r); check("R5 busy ready low", r, 32'h0);
        #1 check("R13 irq busy", irq, 0);
        issue("R4 busy reject", 8'h5A, 8'h01, 16'h0001, 0);
        eng_busy = 1'b0;
        bus_read(8'h08, r); check("R4 cmde on busy", r, 32'h3);

        // back-to-back: second write lands in the start cycle
        cur_req = "R4 back-to-back";
        exp_q.push_back({16'h0011, 8'h08});
        @(negedge clk); bus_addr = 8'h04; bus_wdata = {8'h5A, 16'h0011, 8'h08}; bus_wr = 1'b1;
        @(negedge clk); bus_wdata = {8'h5A, 16'h0022, 8'h09};
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
        check("R4 one start", exp_q.size(), 0);
        bus_read(8'h08, r); check("R4 second rejected", r, 32'h3);

        @(negedge clk); lock_err_in = 1'b1; ecc_err_in = 4'b1001;
        @(negedge clk); lock_err_in = 1'b0; ecc_err_in = 4'b0000;
        bus_read(8'h08, r); check("R7 sticky set", r, 32'h0009_0005);
        bus_read(8'h08, r); check("R7 read clear", r, 32'h1);

        @(negedge clk); bus_addr = 8'h08; bus_rd = 1'b1; ecc_err_in = 4'b0010;
        #1 r = bus_rdata; check("R7 same-cycle old value", r, 32'h1);
        @(negedge clk); bus_rd = 1'b0; ecc_err_in = 4'b0000;
        bus_read(8'h08, r); check("R7 set wins", r, 32'h0002_0001);

        @(negedge clk); flash_err_in = 1'b1;
        @(negedge clk); flash_err_in = 1'b0;
        bus_read(8'h08, r); check("R8 set", r, 32'h9);
        bus_read(8'h08, r); check("R8 survives read", r, 32'h9);
        issue("R8 start clears", 8'h5A, 8'h05, 16'h0000, 1);
        bus_read(8'h08, r); check("R8 cleared", r, 32'h1);

        bus_write(8'hE4, {24'h454642, 8'h01});
        bus_read(8'hE4, r); check("R10 bad key", r, 32'h0);
        bus_write(8'hE4, {24'h454643, 8'h01});
        bus_read(8'hE4, r); check("R10 enable", r, 32'h1);
        bus_write(8'h00, 32'h0);
        bus_read(8'h00, r); check("R11 frozen", r, 32'h0401_0F01);
        bus_write(8'hE4, {24'h454643, 8'h00});
        bus_write(8'h00, 32'h0000_0300);
        bus_read(8'h00, r); check("R11 unfrozen", r, 32'h0000_0300);
        #1 check("R13 irq disabled", irq, 0);

        @(negedge clk); eng_res = 32'hCAFE_0001; eng_res_vld = 1'b1;
        @(negedge clk); eng_res_vld = 1'b0; eng_res = 32'h0;
        bus_read(8'h0C, r); check("R12 result", r, 32'hCAFE_0001);
        bus_read(8'h04, r); check("R12 cmd reads zero", r, 32'h0);
        bus_read(8'h40, r); check("R12 unmapped", r, 32'h0);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule